// File: doc/BRIEF.md
# Bus-Cleared Watchdog Timer

This block supervises the software of a small 8-bit microcontroller. Once a one-time option bit enables it, it counts bus clocks in a divider chain. Software must prove it is alive by writing a word whose bit 0 is zero to one dedicated clear address. If it fails to do so before the selected divider tap is reached, the block sends a one-cycle reset request to the reset controller.

The timeout is chosen by a 2-bit rate code that the timer control register shares with this block. Each code selects a tap four times longer than the one before it. The code is captured only when a new count begins, so changing the code never shortens or lengthens a count that is already running. A stop-mode input freezes the divider while the bus clock is considered halted. The reset request feeds the device reset logic next to the illegal-address detector; both of those are outside this block.

Top module: `cop_watchdog`

## Requirements
- R1: While reset is asserted, and after it, `cop_rst_req` is 0 and the divider count is zero.
- R2: With `opt_cop_en` at 0 the divider is held at zero and `cop_rst_req` never goes high, whatever the bus does.
- R3: Rate code 0, 1, 2 and 3 selects a timeout of 2^BASE_EXP, 2^(BASE_EXP+STEP_EXP), 2^(BASE_EXP+2*STEP_EXP) and 2^(BASE_EXP+3*STEP_EXP) counting cycles. With the defaults 15 and 2 these are 2^15, 2^17, 2^19 and 2^21. `cop_rst_req` rises after the Nth rising edge that follows the edge that took the clear write.
- R4: A bus write (`bus_we`=1) to address CLR_ADDR (default 0x7F0) with `bus_wdata[0]`=0 restarts the count from zero. Bits 7..1 of the data are ignored.
- R5: A write with `bus_wdata[0]`=1, or a write to any other address, leaves the count untouched.
- R6: `cop_rst_req` is high for exactly one cycle. The divider is zero in that cycle and starts a fresh count of the same length.
- R7: The rate code is captured on each clear write, and in the first cycle after reset release. A change between those points takes effect only from the next clear.
- R8: While `stop_mode` is 1 the divider holds its value and no request is raised. Counting resumes where it left off.
- R9: A clear write in the same cycle that would expire the count wins: no request is raised and the count restarts.
- R10: `rst_n` clears the divider asynchronously. Its release is synchronized, so counting starts on the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | CPU write address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | CPU write strobe |
| opt_cop_en | input | 1 | One-time option bit enabling the watchdog |
| rate_sel | input | 2 | Timeout rate code from the timer control register |
| stop_mode | input | 1 | Freezes the divider while high |
| cop_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
On every cycle, the assertions check these points: the request lasts one cycle and coincides with a zeroed divider; a disabled watchdog stays at zero; a qualifying clear write zeroes the count; stop mode freezes it; and the captured rate code changes only when a new count begins. Only the bench scenarios can show that each rate code gives the right absolute timeout, that clear writes are ignored when bit 0 is one or the address differs, and that a clear on the expiry edge suppresses the request. The same holds for a rate change made in mid-count, and for the exact count resumed after stop mode or after a reset release.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int RATE_W    = 2;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int DATA_W    = 8;

  typedef logic [RATE_W-1:0] cop_rate_t;
endpackage

// File: rtl/cop_rst_sync.sv
// Two-flop reset synchronizer: asserts asynchronously, releases on the clock.
module cop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_s = s2_q;
endmodule

// File: rtl/cop_clear_decode.sv
// Recognizes the software clear: a write of bit0 = 0 to the clear address.
module cop_clear_decode #(
  parameter int                ADDR_W   = 11,
  parameter logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'('h7F0)
) (
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [cop_pkg::DATA_W-1:0] bus_wdata,
  output logic                      clr_hit
);
  logic addr_match;
  logic unused_data_hi;

  assign addr_match     = (bus_addr == CLR_ADDR);
  assign clr_hit        = bus_we && addr_match && !bus_wdata[0];
  assign unused_data_hi = ^bus_wdata[cop_pkg::DATA_W-1:1];
endmodule

// File: rtl/cop_rate_latch.sv
// Holds the rate code for the running count; reloads on clear or first cycle.
module cop_rate_latch
  import cop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr_hit,
  input  cop_rate_t rate_sel,
  output cop_rate_t rate_q,
  output logic      armed_q
);
  logic      load;
  cop_rate_t rate_d;
  logic      armed_d;

  always_comb begin
    load    = clr_hit || !armed_q;
    rate_d  = load ? rate_sel : rate_q;
    armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      rate_q  <= rate_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/cop_counter.sv
// Divider with a selectable terminal tap and a registered expiry pulse.
module cop_counter
  import cop_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int STEP_EXP = 2,
  localparam int CNT_W   = BASE_EXP + STEP_EXP * (NUM_RATES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             stop_mode,
  input  logic             clr_hit,
  input  cop_rate_t        rate_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             req_q
);
  logic [CNT_W-1:0] tap_lim [NUM_RATES];
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_d;
  logic             req_d;
  logic             run;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    localparam int TAP_EXP = BASE_EXP + STEP_EXP * g;
    assign tap_lim[g] = CNT_W'((64'd1 << TAP_EXP) - 64'd1);
  end

  assign lim = tap_lim[rate_q];
  assign run = enable && !stop_mode;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (!enable || clr_hit) begin
      cnt_d = '0;
    end else if (run) begin
      if (cnt_q == lim) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int                ADDR_W   = 11,
  parameter logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'('h7F0),
  parameter int                BASE_EXP = 15,
  parameter int                STEP_EXP = 2,
  localparam int               CNT_W    = BASE_EXP + STEP_EXP * (NUM_RATES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              opt_cop_en,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              stop_mode,
  output logic              cop_rst_req
);
  logic             rst_s;
  logic             clr_hit;
  cop_rate_t        rate_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  cop_rst_sync u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  cop_clear_decode #(
    .ADDR_W   (ADDR_W),
    .CLR_ADDR (CLR_ADDR)
  ) u_decode (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .clr_hit   (clr_hit)
  );

  cop_rate_latch u_rate (
    .clk      (clk),
    .rst_n    (rst_s),
    .clr_hit  (clr_hit),
    .rate_sel (rate_sel),
    .rate_q   (rate_q),
    .armed_q  (armed_q)
  );

  cop_counter #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s),
    .enable    (opt_cop_en),
    .stop_mode (stop_mode),
    .clr_hit   (clr_hit),
    .rate_q    (rate_q),
    .cnt_q     (cnt_q),
    .req_q     (cop_rst_req)
  );
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk #(
  parameter int CNT_W = 21
) (
  input logic             clk,
  input logic             rst_s,
  input logic             opt_cop_en,
  input logic             stop_mode,
  input logic             clr_hit,
  input logic             armed_q,
  input logic [1:0]       rate_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cop_rst_req
);
  // R6: request is a single-cycle pulse
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_s)
    cop_rst_req |=> !cop_rst_req);

  // R6: the divider restarts from zero when the request is raised
  p_restart_on_req_r6: assert property (@(posedge clk) disable iff (!rst_s)
    cop_rst_req |-> (cnt_q == '0));

  // R2: disabled watchdog stays at zero and silent
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !opt_cop_en |=> (cnt_q == '0) && !cop_rst_req);

  // R4, R9: a clear write zeroes the count and suppresses the request
  p_clear_zeroes_r4: assert property (@(posedge clk) disable iff (!rst_s)
    clr_hit |=> (cnt_q == '0) && !cop_rst_req);

  // R8: stop mode freezes the divider
  p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (stop_mode && opt_cop_en && !clr_hit) |=> $stable(cnt_q) && !cop_rst_req);

  // R7: captured rate changes only at the start of a count
  p_rate_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (armed_q && !clr_hit) |=> $stable(rate_q));
endmodule

bind cop_watchdog cop_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .opt_cop_en  (opt_cop_en),
  .stop_mode   (stop_mode),
  .clr_hit     (clr_hit),
  .armed_q     (armed_q),
  .rate_q      (rate_q),
  .cnt_q       (cnt_q),
  .cop_rst_req (cop_rst_req)
);

// File: tb/tb_cop_watchdog.sv
`timescale 1ns/1ps
module tb_cop_watchdog;
  localparam int         ADDR_W = 11;
  localparam logic [10:0] CLR    = 11'h7F0;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0]        bus_wdata;
  logic              bus_we;
  logic              opt_cop_en;
  logic [1:0]        rate_sel;
  logic              stop_mode;
  logic              cop_rst_req;

  int checks = 0;
  int errors = 0;
  int kidx, pfirst, pcount;
  bit done = 0;

  // Small taps for simulation: 16, 64, 256, 1024 cycles
  cop_watchdog #(.ADDR_W(ADDR_W), .CLR_ADDR(CLR), .BASE_EXP(4), .STEP_EXP(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .opt_cop_en(opt_cop_en), .rate_sel(rate_sel),
    .stop_mode(stop_mode), .cop_rst_req(cop_rst_req));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {rate, cycles to run, expected first pulse (0 = none)}
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 12'd20,   12'd16},
    {2'd1, 12'd70,   12'd64},
    {2'd2, 12'd260,  12'd256},
    {2'd3, 12'd1030, 12'd1024},
    {2'd0, 12'd15,   12'd0},
    {2'd2, 12'd40,   12'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_watch();
    kidx = 0; pfirst = 0; pcount = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    kidx++;
    if (cop_rst_req) begin
      pcount++;
      if (pfirst == 0) pfirst = kidx;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic clear_and_start();
    bus_write(CLR, 8'h00);
    start_watch();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    opt_cop_en = 1'b1; rate_sel = 2'd0; stop_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 request low in reset", int'(cop_rst_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 timeout per rate code, R6 single pulse
    for (int i = 0; i < 6; i++) begin
      rate_sel = VEC[i][25:24];
      clear_and_start();
      ticks(int'(VEC[i][23:12]));
      chk("R3 first pulse cycle", pfirst, int'(VEC[i][11:0]));
      chk("R6 pulse count", pcount, (VEC[i][11:0] != 0) ? 1 : 0);
    end

    // R2 disabled: no pulse
    rate_sel = 2'd0;
    opt_cop_en = 1'b0;
    clear_and_start();
    ticks(40);
    chk("R2 disabled pulses", pcount, 0);
    opt_cop_en = 1'b1;

    // R5 write of bit0 = 1 to the clear address is ignored
    clear_and_start();
    ticks(9);
    bus_write(CLR, 8'h01);
    ticks(10);
    chk("R5 bit0=1 write ignored", pfirst, 16);

    // R5 write to another address is ignored
    clear_and_start();
    ticks(9);
    bus_write(11'h7EF, 8'h00);
    ticks(10);
    chk("R5 other address ignored", pfirst, 16);

    // R4 mid-count clear with upper data bits set restarts count
    clear_and_start();
    ticks(9);
    bus_write(CLR, 8'hFE);
    ticks(20);
    chk("R4 mid clear restart", pfirst, 26);

    // R7 rate change mid-count has no effect until next clear
    clear_and_start();
    ticks(4);
    rate_sel = 2'd1;
    ticks(16);
    chk("R7 old rate kept mid-count", pfirst, 16);
    clear_and_start();
    ticks(70);
    chk("R7 new rate after clear", pfirst, 64);

    // R8 stop mode freezes the count
    rate_sel = 2'd0;
    clear_and_start();
    ticks(10);
    stop_mode = 1'b1;
    ticks(30);
    chk("R8 no pulse while stopped", pcount, 0);
    stop_mode = 1'b0;
    ticks(10);
    chk("R8 resumed count", pfirst, 46);

    // R9 clear on the expiry edge wins
    clear_and_start();
    ticks(15);
    bus_write(CLR, 8'h00);
    chk("R9 no pulse at expiry edge", pcount, 0);
    ticks(17);
    chk("R9 pulse one period later", pfirst, 32);

    // R10 reset mid-count returns the count to zero
    clear_and_start();
    ticks(10);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 request low in reset", int'(cop_rst_req), 0);
    rst_n = 1'b1;
    start_watch();
    ticks(22);
    chk("R10 first pulse after release", pfirst, 18);
    chk("R1 single pulse after reset", pcount, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule